// File: doc/BRIEF.md
# Dual-Rate Character Dot Serializer

This block converts the contents of one 8-pixel display cell into a serial stream of dots for the raster. Each cell is one of three kinds. A graphics byte is shifted out as 8 dots. A character row from a fixed glyph set is 7 dots wide and 9 rows tall, and carries a spare bit that lowers the glyph inside the cell. A character row from a writable glyph set is 8 dots wide and is stored for up to 16 rows. The caller presents the glyph data and the current raster row within the text line, then pulses a load. The block picks out the row that belongs on that raster line and shifts it out one dot per step enable.

There are two step enables. The pixel enable runs at the normal graphics dot rate. The fast enable runs slightly quicker, so that 7 text dots fill the time of 6 graphics pixels and characters are spaced further apart. Graphics always uses the pixel enable. Fixed-set characters always use the fast enable. Writable-set characters use whichever enable a single screen-wide control bit selects. Two glyph sets are active at a time. The top bit of the character code chooses between two slots, and a per-slot bit states whether that slot holds the fixed set or the writable set.

Top module: `glyph_dot_serializer`

## Requirements
- R1: After reset, `dot_o` is 0, and it stays 0 under any step enables until the first load.
- R2: A fixed-set cell on raster row r (0..8, descender bit 63 clear) sends the 7 bits `fix_glyph[7r+6 : 7r]`, starting with bit 7r+6. It advances only on `fast_en`, and `pix_en` has no effect on it.
- R3: When `fix_glyph[63]` is 1, the glyph is lowered by 3 rows. Raster row r shows stored row r-3 for r in 3..11. Rows 0..2 and row 12 are blank.
- R4: When the descender bit is clear, fixed-set raster rows 9 and above are blank.
- R5: A writable-set cell sends the 8 bits of `byte_in`, starting with bit 7. Raster rows at or above the cell height (13) are blank, so rows 13..15 of a 16-row glyph are dropped.
- R6: Writable cells advance on `fast_en` when `wr_fast` is 1 and on `pix_en` when it is 0. The other enable has no effect.
- R7: When `gfx_mode` is 1, `byte_in` is sent as 8 dots, starting with bit 7, advancing only on `pix_en`, whatever the row and glyph selects are.
- R8: In text mode, `code_hi` indexes `slot_is_wr`. A 1 in the selected bit means the writable set is used, and a 0 means the fixed set is used.
- R9: Once all the dots of a cell have been sent, `dot_o` stays 0 until the next load.
- R10: A load that arrives while a cell is still shifting discards the remaining dots and starts the new cell at its first dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture a new cell at this edge |
| gfx_mode | input | 1 | 1 selects graphics, 0 selects text |
| code_hi | input | 1 | Top bit of the character code (slot select) |
| slot_is_wr | input | 2 | Per-slot kind: 1 means writable set, 0 means fixed set |
| wr_fast | input | 1 | Writable set uses the fast enable |
| pix_en | input | 1 | Normal-rate dot step enable |
| fast_en | input | 1 | Fast text-rate dot step enable |
| cell_row | input | 4 | Raster row within the text line |
| fix_glyph | input | 64 | Whole fixed glyph: 9 rows of 7 bits plus the descender bit 63 |
| byte_in | input | 8 | Writable glyph row for `cell_row`, or graphics byte |
| dot_o | output | 1 | Serial dot output |

## Verification
The bench uses the default parameters: a 7 by 9 fixed glyph, a 3-row descender, an 8-dot field, 16 stored writable rows and a 13-row cell. With these values the 4-bit row input can reach rows 13..15, which are the dropped rows of the writable set. The same values place a descended glyph's last stored row on row 11 and leave row 12 as the guaranteed blank line. Holding each enable alone shows which rate each kind of cell follows, because a cell on the wrong enable freezes on its first dot.

// File: rtl/glyph_ser_pkg.sv
package glyph_ser_pkg;
   typedef enum logic [1:0] {
      SRC_GFX = 2'd0,
      SRC_FIX = 2'd1,
      SRC_WR  = 2'd2
   } src_e;
endpackage

// File: rtl/glyph_row_pick.sv
module glyph_row_pick
   import glyph_ser_pkg::*;
#(
   parameter int FIX_W      = 7,
   parameter int FIX_H      = 9,
   parameter int DESC_LINES = 3,
   parameter int WR_W       = 8,
   parameter int CELL_H     = 13,
   parameter int ROW_W      = 4,
   parameter int CNT_W      = 4
) (
   input  src_e                   src,
   input  logic [FIX_W*FIX_H:0]   fix_glyph,
   input  logic [WR_W-1:0]        byte_in,
   input  logic [ROW_W-1:0]       cell_row,
   output logic [WR_W-1:0]        pattern,
   output logic [CNT_W-1:0]       dots
);
   localparam int FIX_BITS = FIX_W * FIX_H + 1;

   int          desc_off;
   logic [FIX_W-1:0] fix_row;

   generate
      if (DESC_LINES > 0) begin : g_desc
         always_comb desc_off = fix_glyph[FIX_BITS-1] ? DESC_LINES : 0;
      end else begin : g_nodesc
         always_comb desc_off = 0;
      end
   endgenerate

   always_comb begin
      int sr;
      sr = int'(cell_row) - desc_off;
      fix_row = '0;
      if (sr >= 0 && sr < FIX_H)
         fix_row = fix_glyph[sr*FIX_W +: FIX_W];
   end

   always_comb begin
      pattern = '0;
      dots    = CNT_W'(WR_W);
      unique case (src)
         SRC_GFX: pattern = byte_in;
         SRC_FIX: begin
            dots = CNT_W'(FIX_W);
            if (int'(cell_row) < CELL_H)
               pattern = {fix_row, {(WR_W-FIX_W){1'b0}}};
         end
         SRC_WR: begin
            if (int'(cell_row) < CELL_H)
               pattern = byte_in;
         end
         default: pattern = '0;
      endcase
   end

   // R3: rows above a lowered glyph stay blank
   always_comb begin
      if (src == SRC_FIX && DESC_LINES > 0 && fix_glyph[FIX_BITS-1] &&
          int'(cell_row) < DESC_LINES)
         AST_DESC_TOP_BLANK: assert (pattern == '0); // R3
   end
endmodule

// File: rtl/dot_shifter.sv
module dot_shifter #(
   parameter int WR_W  = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WR_W-1:0]  pattern,
   input  logic [CNT_W-1:0] dots,
   input  logic             fast_sel,
   input  logic             pix_en,
   input  logic             fast_en,
   output logic             dot_o
);
   logic [WR_W-1:0]  shreg;
   logic [CNT_W-1:0] remain;
   logic             fast_q;
   logic             step;

   assign step  = fast_q ? fast_en : pix_en;
   assign dot_o = shreg[WR_W-1] & (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '0;
         remain <= '0;
         fast_q <= 1'b0;
      end else if (load) begin
         shreg  <= pattern;
         remain <= dots;
         fast_q <= fast_sel;
      end else if (step && remain != '0) begin
         shreg  <= {shreg[WR_W-2:0], 1'b0};
         remain <= remain - 1'b1;
      end
   end

   AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !load && step && remain != '0 |=> remain == $past(remain) - 1'b1); // R2
   AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step |=> $stable(shreg) && $stable(remain)); // R6
   AST_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !load && remain == '0 |=> remain == '0 && !dot_o); // R9
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> remain == $past(dots) && shreg == $past(pattern)); // R10
endmodule

// File: rtl/glyph_dot_serializer.sv
module glyph_dot_serializer
   import glyph_ser_pkg::*;
#(
   parameter int FIX_W      = 7,
   parameter int FIX_H      = 9,
   parameter int DESC_LINES = 3,
   parameter int WR_W       = 8,
   parameter int WR_ROWS    = 16,
   parameter int CELL_H     = 13,
   localparam int ROW_W     = $clog2(WR_ROWS),
   localparam int FIX_BITS  = FIX_W * FIX_H + 1,
   localparam int CNT_W     = $clog2(WR_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                gfx_mode,
   input  logic                code_hi,
   input  logic [1:0]          slot_is_wr,
   input  logic                wr_fast,
   input  logic                pix_en,
   input  logic                fast_en,
   input  logic [ROW_W-1:0]    cell_row,
   input  logic [FIX_BITS-1:0] fix_glyph,
   input  logic [WR_W-1:0]     byte_in,
   output logic                dot_o
);
   generate
      if (WR_W <= FIX_W)
         $error("field must be wider than a fixed glyph row");
      if (FIX_H + DESC_LINES >= CELL_H)
         $error("cell must keep one blank raster row");
      if (CELL_H > WR_ROWS)
         $error("cell taller than stored writable rows");
   endgenerate

   src_e             src;
   logic             fast_sel;
   logic [WR_W-1:0]  pick_pat;
   logic [CNT_W-1:0] pick_dots;

   always_comb begin
      if (gfx_mode)                src = SRC_GFX;
      else if (slot_is_wr[code_hi]) src = SRC_WR;
      else                         src = SRC_FIX;
   end

   assign fast_sel = (src == SRC_FIX) || (src == SRC_WR && wr_fast);

   glyph_row_pick #(
      .FIX_W(FIX_W), .FIX_H(FIX_H), .DESC_LINES(DESC_LINES),
      .WR_W(WR_W), .CELL_H(CELL_H), .ROW_W(ROW_W), .CNT_W(CNT_W)
   ) i_pick (
      .src(src), .fix_glyph(fix_glyph), .byte_in(byte_in),
      .cell_row(cell_row), .pattern(pick_pat), .dots(pick_dots)
   );

   dot_shifter #(.WR_W(WR_W), .CNT_W(CNT_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .pattern(pick_pat),
      .dots(pick_dots), .fast_sel(fast_sel), .pix_en(pix_en),
      .fast_en(fast_en), .dot_o(dot_o)
   );

   AST_FIX_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
      load && !gfx_mode && !slot_is_wr[code_hi] |-> pick_dots == CNT_W'(FIX_W) && fast_sel); // R2
   AST_GFX_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      load && gfx_mode |-> pick_dots == CNT_W'(WR_W) && !fast_sel && pick_pat == byte_in); // R7
   AST_WR_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      load && !gfx_mode && slot_is_wr[code_hi] |-> fast_sel == wr_fast); // R6
endmodule

// File: tb/test_glyph_dot_serializer.sv
module test_glyph_dot_serializer;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        load = 0, gfx_mode = 0, code_hi = 0, wr_fast = 0;
   logic        pix_en = 0, fast_en = 0;
   logic [1:0]  slot_is_wr = 2'b10;
   logic [3:0]  cell_row = 0;
   logic [63:0] fix_glyph = 0;
   logic [7:0]  byte_in = 0;
   logic        dot_o;
   int checks = 0, failures = 0;
   logic [15:0] seq;
   logic [63:0] fg;

   always #4 clk = ~clk;

   glyph_dot_serializer i_glyph_dot_serializer (
      .clk(clk), .rst_n(rst_n), .load(load), .gfx_mode(gfx_mode),
      .code_hi(code_hi), .slot_is_wr(slot_is_wr), .wr_fast(wr_fast),
      .pix_en(pix_en), .fast_en(fast_en), .cell_row(cell_row),
      .fix_glyph(fix_glyph), .byte_in(byte_in), .dot_o(dot_o));

   function automatic logic [6:0] frow(int r);
      return 7'h40 | 7'((r * 37 + 11) & 63);
   endfunction

   function automatic logic [63:0] make_glyph(logic desc);
      logic [63:0] g;
      g = '0;
      for (int r = 0; r < 9; r++) g[7*r +: 7] = frow(r);
      g[63] = desc;
      return g;
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // called at a negedge; pulses load across one posedge
   task automatic do_load(input logic g, input logic hi, input logic [3:0] row);
      gfx_mode = g; code_hi = hi; cell_row = row;
      fix_glyph = fg; load = 1;
      @(negedge clk);
      load = 0;
   endtask

   task automatic capture(input logic pe, input logic fe, input int n);
      seq = '0;
      for (int i = 0; i < n; i++) begin
         seq = {seq[14:0], dot_o};
         pix_en = pe; fast_en = fe;
         @(negedge clk);
      end
      pix_en = 0; fast_en = 0;
   endtask

   task automatic t_reset;
      chk("R1 reset", {15'd0, dot_o}, 16'd0);
      capture(1, 1, 10);
      chk("R1 idle before load", seq, 16'd0);
   endtask

   task automatic t_fixed;
      fg = make_glyph(0); slot_is_wr = 2'b10;
      do_load(0, 0, 4'd2); capture(0, 1, 10);
      chk("R2 fixed row2 fast", seq, {6'd0, frow(2), 3'b000});
      do_load(0, 0, 4'd8); capture(0, 1, 10);
      chk("R2 fixed row8 fast", seq, {6'd0, frow(8), 3'b000});
      do_load(0, 0, 4'd2); capture(1, 0, 10);
      chk("R2 fixed ignores pix_en", seq, 16'h03FF);
      do_load(0, 0, 4'd9); capture(0, 1, 10);
      chk("R4 row9 blank", seq, 16'd0);
      do_load(0, 0, 4'd12); capture(0, 1, 10);
      chk("R4 row12 blank", seq, 16'd0);
   endtask

   task automatic t_desc;
      fg = make_glyph(1); slot_is_wr = 2'b10;
      do_load(0, 0, 4'd5); capture(0, 1, 10);
      chk("R3 desc row5 shows 2", seq, {6'd0, frow(2), 3'b000});
      do_load(0, 0, 4'd11); capture(0, 1, 10);
      chk("R3 desc row11 shows 8", seq, {6'd0, frow(8), 3'b000});
      do_load(0, 0, 4'd1); capture(0, 1, 10);
      chk("R3 desc row1 blank", seq, 16'd0);
      do_load(0, 0, 4'd12); capture(0, 1, 10);
      chk("R3 desc row12 blank", seq, 16'd0);
   endtask

   task automatic t_writable;
      fg = make_glyph(0); slot_is_wr = 2'b10; byte_in = 8'hB5;
      wr_fast = 1;
      do_load(0, 1, 4'd4); capture(0, 1, 10);
      chk("R5 R8 writable fast", seq, {6'd0, 8'hB5, 2'b00});
      do_load(0, 1, 4'd4); capture(1, 0, 10);
      chk("R6 writable fast ignores pix_en", seq, 16'h03FF);
      wr_fast = 0;
      do_load(0, 1, 4'd4); capture(1, 0, 10);
      chk("R6 writable slow", seq, {6'd0, 8'hB5, 2'b00});
      do_load(0, 1, 4'd4); capture(0, 1, 10);
      chk("R6 writable slow ignores fast_en", seq, 16'h03FF);
      do_load(0, 1, 4'd13); capture(1, 1, 10);
      chk("R5 row13 dropped", seq, 16'd0);
      do_load(0, 1, 4'd15); capture(1, 1, 10);
      chk("R5 row15 dropped", seq, 16'd0);
   endtask

   task automatic t_slots;
      fg = make_glyph(0); byte_in = 8'hB5; wr_fast = 1;
      slot_is_wr = 2'b01;
      do_load(0, 0, 4'd3); capture(0, 1, 10);
      chk("R8 slot0 writable", seq, {6'd0, 8'hB5, 2'b00});
      do_load(0, 1, 4'd3); capture(0, 1, 10);
      chk("R8 slot1 fixed", seq, {6'd0, frow(3), 3'b000});
   endtask

   task automatic t_gfx;
      fg = make_glyph(1); slot_is_wr = 2'b00; byte_in = 8'h9C;
      do_load(1, 0, 4'd14); capture(1, 0, 10);
      chk("R7 gfx pix rate", seq, {6'd0, 8'h9C, 2'b00});
      do_load(1, 1, 4'd0); capture(0, 1, 10);
      chk("R7 gfx ignores fast_en", seq, 16'h03FF);
      do_load(1, 0, 4'd0); capture(1, 0, 14);
      chk("R9 held low after cell", seq, {2'd0, 8'h9C, 6'd0});
   endtask

   task automatic t_reload;
      fg = make_glyph(0); slot_is_wr = 2'b00; byte_in = 8'hFF;
      do_load(1, 0, 4'd0); capture(1, 0, 3);
      chk("R10 first cell started", seq, 16'h0007);
      byte_in = 8'h81;
      do_load(1, 0, 4'd0); capture(1, 0, 10);
      chk("R10 reload restarts", seq, {6'd0, 8'h81, 2'b00});
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            t_reset;
            t_fixed;
            t_desc;
            t_writable;
            t_slots;
            t_gfx;
            t_reload;
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule